// File: doc/BRIEF.md
# Streaming Binary Erosion Filter

This block removes small foreground specks from a binary mask that arrives one pixel per clock in raster order. It keeps the most recent lines of the stream in a shift register. Over that history it forms a square neighbourhood of 3x3 or 4x4 pixels. A runtime enable mask picks which neighbourhood positions take part. The output bit is 1 only when every selected position holds a 1. A 4x4 element has no exact centre, so its anchor sits on the upper-left pixel of the central four.

A frame starts with a start-of-frame marker on its first pixel. The size and the mask are captured on that pixel and hold for the whole frame. The input may pause at any point inside a frame. The output comes out in raster order, with one result per input pixel and a fixed lag counted in pixels. When the last input pixel has arrived, the block produces the remaining results by itself at one per clock. Positions outside the image count as foreground, so the border of the image does not erode an object.

Top module: `bin_erode`

## Requirements
- R1: After reset, out_valid is low and stays low until a frame has been started.
- R2: The values of se_big (0 selects 3x3, 1 selects 4x4) and se_mask are captured on the pixel that carries in_sof, and later changes on those inputs have no effect until the next frame starts. Mask bit 4*i+j enables element row i (0 is the top row) and column j (0 is the left column). With 3x3, bits in row 3 or column 3 are ignored.
- R3: out_bit for pixel (r,c) is the AND of every enabled element position that falls inside the image. A lone foreground pixel is cleared by a full 3x3 element.
- R4: Element row i and column j cover image pixel (r+i-1, c+j-1). This places the anchor at the centre of a 3x3 element and at the upper-left pixel of the central four for a 4x4 element.
- R5: Element positions that fall outside the image count as 1.
- R6: An all-zero mask gives out_bit = 1 for every pixel.
- R7: Exactly W*H results come out per frame, in raster order. The result for pixel q is valid in the cycle after input pixel q+L is sampled, where L = W+1 for 3x3 and L = 2W+2 for 4x4.
- R8: After the last input pixel of a frame, the final L results come out on consecutive clocks with no further input.
- R9: A pixel with in_valid high but without in_sof is ignored, and produces no output, when it arrives before any frame or after a frame's W*H pixels.
- R10: Idle cycles inside a frame (in_valid low) delay the output but do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame; the element configuration is captured here |
| in_eol | input | 1 | Last pixel of a line |
| in_bit | input | 1 | Foreground bit of the input pixel |
| se_big | input | 1 | Element size: 0 = 3x3, 1 = 4x4 |
| se_mask | input | 16 | Element enables, bit 4*i+j for row i, column j |
| out_valid | output | 1 | Eroded pixel present |
| out_bit | output | 1 | Eroded foreground bit |

## Verification
The assertions assume that a new frame starts only after the previous frame has finished its output, including the self-driven tail. They also assume that in_eol is high exactly on the last column of each line. The stimulus meets both conditions. It waits longer than the 4x4 tail before each start marker, and it raises the line marker from the same column count it uses to build each frame. Stray pixels without a start marker fall outside both conditions, and they are sent only while the block is idle.

// File: rtl/bin_erode.sv
module bin_erode #(
  parameter int W = 16,
  parameter int H = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eol,
  input  logic        in_bit,
  input  logic        se_big,
  input  logic [15:0] se_mask,
  output logic        out_valid,
  output logic        out_bit
);
  localparam int NPIX  = W * H;
  localparam int LMAX  = 2 * W + 2;
  localparam int DEPTH = 3 * W + 3;
  localparam int CW    = $clog2(NPIX + LMAX + 1);
  localparam int XW    = $clog2(W);
  localparam int YW    = $clog2(H);
  localparam logic [CW-1:0] NPIX_C = CW'(NPIX);

  logic [CW-1:0]  k;
  logic           cfg_big;
  logic [15:0]    cfg_mask;
  logic [DEPTH-1:0] sr;
  logic [XW-1:0]  ocol, icol;
  logic [YW-1:0]  orow;
  logic           eroded;

  wire [CW-1:0] lat      = cfg_big ? CW'(LMAX) : CW'(W + 1);
  wire          start    = in_valid && in_sof;
  wire          in_frame = k < NPIX_C;
  wire          flushing = !start && !in_frame && (k < NPIX_C + lat);
  wire          take     = start || (in_valid && in_frame);
  wire          adv      = take || flushing;
  wire          emit     = adv && !start && (k >= lat);
  wire          win0     = take ? in_bit : 1'b1;
  wire [DEPTH:0] win     = {sr, win0};
  wire          anchor_bit = cfg_big ? win[2*W+2] : win[W+1];

  always_comb begin
    eroded = 1'b1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int rr, cc, idx;
        rr  = int'(orow) + i - 1;
        cc  = int'(ocol) + j - 1;
        idx = cfg_big ? (3 - i) * W + (3 - j) : (2 - i) * W + (2 - j);
        if (cfg_mask[4*i+j] && (cfg_big || (i < 3 && j < 3)) &&
            rr >= 0 && rr < H && cc >= 0 && cc < W && !win[idx])
          eroded = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k        <= CW'(NPIX + LMAX);
      cfg_big  <= 1'b0;
      cfg_mask <= '0;
      sr       <= '1;
      orow     <= '0;
      ocol     <= '0;
      icol     <= '0;
    end else begin
      if (adv) begin
        sr <= win[DEPTH-1:0];
        k  <= start ? CW'(1) : k + CW'(1);
      end
      if (start) begin
        cfg_big  <= se_big;
        cfg_mask <= se_mask;
        orow     <= '0;
        ocol     <= '0;
        icol     <= XW'(1);
      end else begin
        if (emit) begin
          if (ocol == XW'(W - 1)) begin
            ocol <= '0;
            orow <= orow + YW'(1);
          end else begin
            ocol <= ocol + XW'(1);
          end
        end
        if (take)
          icol <= (icol == XW'(W - 1)) ? '0 : icol + XW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) out_bit <= eroded;
    end
  end

  p_sof_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (k >= NPIX_C + lat));

  p_eol_position: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start) |-> (in_eol == (icol == XW'(W - 1))));

  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && k >= NPIX_C + lat) |=> !out_valid);

  p_tail_self_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> out_valid);

  p_empty_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mask == 16'h0) |-> out_bit);

  p_no_growth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && cfg_mask[5]) |=> (!out_bit || $past(anchor_bit)));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/bin_erode_test.sv
`timescale 1ns/1ps
module bin_erode_test;
  localparam int W = 8;
  localparam int H = 6;
  localparam int NPIX = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_bit = 1'b0;
  logic se_big = 1'b0;
  logic [15:0] se_mask = '0;
  logic out_valid, out_bit;

  bin_erode #(.W(W), .H(H)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_bit(in_bit), .se_big(se_big), .se_mask(se_mask),
    .out_valid(out_valid), .out_bit(out_bit));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit img [NPIX];
  bit got [NPIX];
  int got_cyc [NPIX];
  int in_edge [NPIX];
  int oidx = 0;
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always @(negedge clk) begin
    if (out_valid) begin
      if (oidx < NPIX) begin
        got[oidx] = out_bit;
        got_cyc[oidx] = cyc;
      end
      oidx++;
    end
  end

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic bit ref_px(int r, int c, bit big, logic [15:0] mask);
    int s;
    s = big ? 4 : 3;
    for (int i = 0; i < s; i++)
      for (int j = 0; j < s; j++) begin
        int rr, cc;
        rr = r + i - 1;
        cc = c + j - 1;
        if (mask[4*i+j] && rr >= 0 && rr < H && cc >= 0 && cc < W && !img[rr*W+cc])
          return 1'b0;
      end
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(bit big, logic [15:0] mask, bit gaps, bit scramble);
    int lat, last;
    lat = big ? 2 * W + 2 : W + 1;
    oidx = 0;
    se_big = big;
    se_mask = mask;
    for (int n = 0; n < NPIX; n++) begin
      @(negedge clk);
      if (gaps && (n % 3 == 2)) begin
        in_valid = 1'b0;
        in_sof = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof = (n == 0);
      in_eol = (n % W == W - 1);
      in_bit = img[n];
      in_edge[n] = cyc + 1;
      if (scramble && n == 1) begin
        se_big = ~big;
        se_mask = ~mask;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eol = 1'b0;
    last = in_edge[NPIX-1];
    repeat (2 * W + 8) @(negedge clk);
    check(oidx == NPIX, "R7", "result count", oidx, NPIX);
    begin
      int bad_main, bad_tail, first_q, first_exp;
      bad_main = 0; bad_tail = 0; first_q = -1; first_exp = 0;
      for (int q = 0; q < NPIX; q++) begin
        int e;
        if (q + lat < NPIX) begin
          e = in_edge[q + lat];
          if (got_cyc[q] != e) begin
            bad_main++;
            if (first_q < 0) begin first_q = q; first_exp = e; end
          end
        end else begin
          e = last + (q + lat - NPIX + 1);
          if (got_cyc[q] != e) begin
            bad_tail++;
            if (first_q < 0) begin first_q = q; first_exp = e; end
          end
        end
      end
      check(bad_main == 0, "R7", "result timing (cycle of first late pixel)",
            first_q < 0 ? 0 : got_cyc[first_q], first_exp);
      check(bad_tail == 0, "R8", "tail timing (mismatching tail pixels)", bad_tail, 0);
    end
  endtask

  task automatic compare(bit big, logic [15:0] mask, string req);
    int bad, fq;
    bad = 0; fq = -1;
    for (int q = 0; q < NPIX; q++)
      if (got[q] != ref_px(q / W, q % W, big, mask)) begin
        bad++;
        if (fq < 0) fq = q;
      end
    check(bad == 0, req, "eroded data (mismatching pixels)", bad, 0);
  endtask

  function automatic int ones();
    int s;
    s = 0;
    for (int q = 0; q < NPIX; q++) s += got[q];
    return s;
  endfunction

  task automatic fill_random(int density);
    for (int q = 0; q < NPIX; q++) img[q] = (rnd() % 4) < density;
  endtask

  task automatic stray_pixels(string req);
    oidx = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = 1'b0;
      in_eol = 1'b0;
      in_bit = n[0];
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2 * W + 8) @(negedge clk);
    check(oidx == 0, req, "results from pixels without start marker", oidx, 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    stray_pixels("R9");
  endtask

  task automatic t_speck();
    for (int q = 0; q < NPIX; q++) img[q] = 1'b0;
    img[2*W+3] = 1'b1;
    run_frame(1'b0, 16'h0777, 1'b0, 1'b0);
    check(ones() == 0, "R3", "lone pixel survivors", ones(), 0);
    fill_random(3);
    run_frame(1'b0, 16'h0272, 1'b0, 1'b0);
    compare(1'b0, 16'h0272, "R3");
    fill_random(3);
    run_frame(1'b1, 16'hA5F3, 1'b0, 1'b0);
    compare(1'b1, 16'hA5F3, "R3");
  endtask

  task automatic t_anchor();
    for (int q = 0; q < NPIX; q++)
      img[q] = (q / W >= 1 && q / W <= 4 && q % W >= 2 && q % W <= 5);
    run_frame(1'b1, 16'hFFFF, 1'b0, 1'b0);
    check(ones() == 1, "R4", "4x4 survivors", ones(), 1);
    check(got[2*W+3] == 1'b1, "R4", "4x4 anchor pixel (2,3)", got[2*W+3], 1);
    run_frame(1'b0, 16'h0777, 1'b0, 1'b0);
    check(ones() == 4, "R4", "3x3 survivors", ones(), 4);
    check(got[2*W+3] && got[3*W+4], "R4", "3x3 centre survivors", got[2*W+3] + got[3*W+4], 2);
  endtask

  task automatic t_border();
    for (int q = 0; q < NPIX; q++) img[q] = 1'b1;
    run_frame(1'b1, 16'hFFFF, 1'b0, 1'b0);
    check(ones() == NPIX, "R5", "all-ones image survivors", ones(), NPIX);
    for (int q = 0; q < NPIX; q++) img[q] = (q % W != 4);
    run_frame(1'b0, 16'h0777, 1'b0, 1'b0);
    check(got[0] == 1'b1, "R5", "corner pixel kept", got[0], 1);
    compare(1'b0, 16'h0777, "R5");
  endtask

  task automatic t_zero_mask();
    fill_random(1);
    run_frame(1'b1, 16'h0000, 1'b0, 1'b0);
    check(ones() == NPIX, "R6", "ones with empty mask", ones(), NPIX);
  endtask

  task automatic t_config();
    fill_random(3);
    run_frame(1'b0, 16'hFFFF, 1'b0, 1'b0);
    compare(1'b0, 16'h0777, "R2");
    fill_random(3);
    run_frame(1'b1, 16'h3366, 1'b0, 1'b1);
    compare(1'b1, 16'h3366, "R2");
  endtask

  task automatic t_gaps();
    fill_random(3);
    run_frame(1'b1, 16'hFFFF, 1'b1, 1'b0);
    compare(1'b1, 16'hFFFF, "R10");
    fill_random(3);
    run_frame(1'b0, 16'h0777, 1'b1, 1'b0);
    compare(1'b0, 16'h0777, "R10");
    stray_pixels("R9");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_speck();
    t_anchor();
    t_border();
    t_zero_mask();
    t_config();
    t_gaps();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", "run did not finish", cyc, 0);
      summary();
    end
  end
endmodule